// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Registered Flags

This block is the arithmetic and logic core of an 8-bit accumulator datapath. Every operation code produces its 8-bit result combinationally, in the same cycle, from the accumulator input, the operand input and the flag byte currently held. A companion 16-bit adder forms the sum of a register pair and the HL pair. Operand fetch, addressing and instruction decode sit outside the block.

The flag byte is the only state in the block. On a clock edge where `op_valid` is high, the flag byte takes the value given by the update rule of the operation class presented. This is how the surrounding datapath retires one operation per cycle. Each class changes its own subset of the five flags. Some classes touch only carry, and some touch no flag at all.

Top module: `acc_alu`

## Requirements
- R1: `flags` is {S, Z, AC, P, CY} from bit 4 down to bit 0. It resets to 0 while `rst_n` is low. It changes only on a clock edge where `op_valid` is high. With `op_valid` low it holds, whatever the other inputs are.
- R2: ADD (code 0) and ADC (code 1) give result = acc + opnd (+ CY for ADC) modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3. S is bit 7 of the result, Z is set for a zero result, and P is 1 when the result has an even number of one bits.
- R3: SUB (code 2) and SBB (code 3) give result = acc − opnd (− CY for SBB) modulo 256. CY holds the borrow out of bit 7 and AC holds the borrow out of bit 3. S, Z and P follow the rules of R2.
- R4: CMP (code 6) leaves `result` equal to `acc_in`. Its flags are those of SUB, so CY is set when acc < opnd, Z is set when they are equal, and both are clear when acc > opnd.
- R5: INC (code 4) and DEC (code 5) return opnd + 1 or opnd − 1 modulo 256. They update S, Z, P and AC (carry into, or borrow out of, bit 4) and leave CY unchanged.
- R6: AND (code 7) returns acc & opnd. It updates S, Z and P, sets AC and clears CY.
- R7: OR (code 8) and XOR (code 9) return acc | opnd and acc ^ opnd. They update S, Z and P and clear AC and CY.
- R8: RLC (code 10) rotates acc left and copies bit 7 into bit 0 and into CY. RRC (code 11) rotates acc right and copies bit 0 into bit 7 and into CY. No other flag changes.
- R9: RAL (code 12) shifts acc left, with the old CY entering bit 0 and bit 7 going to CY. RAR (code 13) shifts acc right, with the old CY entering bit 7 and bit 0 going to CY. No other flag changes.
- R10: CMA (code 14) returns ~acc and changes no flag. STC (code 15) sets CY, and CMC (code 16) inverts CY. Both leave the other flags and return acc unchanged.
- R11: DAA (code 17) adds 6 when the low nibble of acc exceeds 9 or AC is set. It then adds 0x60 when the high nibble of that sum exceeds 9, or CY is set, or the first step carried out of bit 7. CY is set when the 0x60 step is taken. AC is set when the low nibble exceeded 9. S, Z and P follow the result.
- R12: `hl_sum` is always (hl_in + pair_in) modulo 65536. DAD (code 18) loads CY with the carry out of bit 15, leaves S, Z, AC and P alone, and returns acc.
- R13: Codes 19 to 31 return acc and leave every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag byte |
| op_valid | input | 1 | Commit the flag update of this cycle's operation |
| op_code | input | OPW | Operation code |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand value |
| hl_in | input | 16 | HL pair for the 16-bit add |
| pair_in | input | 16 | Register pair added to HL |
| result | output | 8 | 8-bit result |
| hl_sum | output | 16 | 16-bit sum |
| flags | output | 5 | Registered {S, Z, AC, P, CY} |

## Verification
The bench goes after the nibble boundaries: INC of 0x0F, DEC of 0x00, and ADD and SUB cases that carry or borrow exactly at bit 3. A design that took AC from the wrong bit would fail these cases while its 8-bit results still matched. DAA is driven with a low nibble above 9, with AC set, and with an input near 0xFF whose first correction overflows; a design that tested the high nibble before the low fix would return the wrong BCD digit or lose CY. The carry-only classes (rotates, STC, CMC, DAD) run with S, Z, AC and P preset. CMA, undefined codes and cycles with `op_valid` low are checked for an untouched flag byte, so a leaked flag write shows up at once.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int OPW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [7:0]     acc_in,
  input  logic [7:0]     opnd_in,
  input  logic [15:0]    hl_in,
  input  logic [15:0]    pair_in,
  output logic [7:0]     result,
  output logic [15:0]    hl_sum,
  output logic [4:0]     flags
);
  localparam logic [OPW-1:0] K_ADD = OPW'(0),  K_ADC = OPW'(1),  K_SUB = OPW'(2);
  localparam logic [OPW-1:0] K_SBB = OPW'(3),  K_INC = OPW'(4),  K_DEC = OPW'(5);
  localparam logic [OPW-1:0] K_CMP = OPW'(6),  K_AND = OPW'(7),  K_OR  = OPW'(8);
  localparam logic [OPW-1:0] K_XOR = OPW'(9),  K_RLC = OPW'(10), K_RRC = OPW'(11);
  localparam logic [OPW-1:0] K_RAL = OPW'(12), K_RAR = OPW'(13), K_CMA = OPW'(14);
  localparam logic [OPW-1:0] K_STC = OPW'(15), K_CMC = OPW'(16), K_DAA = OPW'(17);
  localparam logic [OPW-1:0] K_DAD = OPW'(18);

  logic       cy, ac, cin;
  logic [8:0] add9, sub9, fix1, fix2;
  logic [4:0] addlo, sublo;
  logic       lo_fix, hi_fix;
  logic [16:0] wide;
  logic [7:0] res;
  logic [4:0] nf;

  assign cy  = flags[0];
  assign ac  = flags[2];
  assign cin = (op_code == K_ADC || op_code == K_SBB) ? cy : 1'b0;

  assign add9  = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin};
  assign addlo = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin};
  assign sub9  = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cin};
  assign sublo = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cin};

  assign lo_fix = (acc_in[3:0] > 4'd9) || ac;
  assign fix1   = {1'b0, acc_in} + (lo_fix ? 9'h006 : 9'h000);
  assign hi_fix = (fix1[7:4] > 4'd9) || cy || fix1[8];
  assign fix2   = fix1 + (hi_fix ? 9'h060 : 9'h000);

  assign wide   = {1'b0, hl_in} + {1'b0, pair_in};
  assign hl_sum = wide[15:0];
  assign result = res;

  function automatic logic [4:0] szp(input logic [7:0] r, input logic a, input logic c);
    return {r[7], r == 8'd0, a, ~^r, c};
  endfunction

  always_comb begin
    res = acc_in;
    nf  = flags;
    case (op_code)
      K_ADD, K_ADC: begin res = add9[7:0]; nf = szp(add9[7:0], addlo[4], add9[8]); end
      K_SUB, K_SBB: begin res = sub9[7:0]; nf = szp(sub9[7:0], sublo[4], sub9[8]); end
      K_CMP:        nf = szp(sub9[7:0], sublo[4], sub9[8]);
      K_INC: begin res = opnd_in + 8'd1; nf = szp(res, opnd_in[3:0] == 4'hF, cy); end
      K_DEC: begin res = opnd_in - 8'd1; nf = szp(res, opnd_in[3:0] == 4'h0, cy); end
      K_AND: begin res = acc_in & opnd_in; nf = szp(res, 1'b1, 1'b0); end
      K_OR:  begin res = acc_in | opnd_in; nf = szp(res, 1'b0, 1'b0); end
      K_XOR: begin res = acc_in ^ opnd_in; nf = szp(res, 1'b0, 1'b0); end
      K_RLC: begin res = {acc_in[6:0], acc_in[7]}; nf[0] = acc_in[7]; end
      K_RRC: begin res = {acc_in[0], acc_in[7:1]}; nf[0] = acc_in[0]; end
      K_RAL: begin res = {acc_in[6:0], cy};        nf[0] = acc_in[7]; end
      K_RAR: begin res = {cy, acc_in[7:1]};        nf[0] = acc_in[0]; end
      K_CMA: res = ~acc_in;
      K_STC: nf[0] = 1'b1;
      K_CMC: nf[0] = ~cy;
      K_DAA: begin res = fix2[7:0]; nf = szp(fix2[7:0], acc_in[3:0] > 4'd9, hi_fix); end
      K_DAD: nf[0] = wide[16];
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flags <= '0;
    else if (op_valid) flags <= nf;
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int OPW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           op_valid,
  input logic [OPW-1:0] op_code,
  input logic [7:0]     acc_in,
  input logic [7:0]     opnd_in,
  input logic [7:0]     result,
  input logic [4:0]     flags
);
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(flags));

  p_add_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(0)) |=> (flags[3] == ($past(result) == 8'd0)));

  p_cmp_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(6) && acc_in == opnd_in) |=> (flags[3] && !flags[0]));

  p_incdec_cy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OPW'(4) || op_code == OPW'(5))) |=> (flags[0] == $past(flags[0])));

  p_and_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(7)) |=> (flags[2] && !flags[0]));

  p_orxor_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OPW'(8) || op_code == OPW'(9))) |=> (!flags[2] && !flags[0]));

  p_rot_cy_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OPW'(10) || op_code == OPW'(11))) |=> (flags[4:1] == $past(flags[4:1])));

  p_rotc_cy_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OPW'(12) || op_code == OPW'(13))) |=> (flags[4:1] == $past(flags[4:1])));

  p_cma_noflag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(14)) |=> $stable(flags));

  p_stc_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(15)) |=> flags[0]);

  p_dad_cy_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPW'(18)) |=> (flags[4:1] == $past(flags[4:1])));

  p_undef_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code > OPW'(18)) |=> $stable(flags));
endmodule

bind acc_alu acc_alu_chk #(.OPW(OPW)) u_chk (.*);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [4:0]  op_code = '0;
  logic [7:0]  acc_in = '0, opnd_in = '0;
  logic [15:0] hl_in = '0, pair_in = '0;
  logic [7:0]  result;
  logic [15:0] hl_sum;
  logic [4:0]  flags;

  int n_run = 0, n_fail = 0, mflags = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut (.*);

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R2";
      2, 3: return "R3";
      6: return "R4";
      4, 5: return "R5";
      7: return "R6";
      8, 9: return "R7";
      10, 11: return "R8";
      12, 13: return "R9";
      14, 15, 16: return "R10";
      17: return "R11";
      18: return "R12";
      default: return "R13";
    endcase
  endfunction

  function automatic int pack(input int r, input int a, input int c);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
    return (((r >> 7) & 1) << 4) | ((r == 0) << 3) | (a << 2) | (((ones % 2) == 0) << 1) | c;
  endfunction

  task automatic model(input int op, input int a, input int b, input int hl, input int pr,
                       input int f, output int r, output int w, output int nf);
    int cy = f & 1, ac = (f >> 2) & 1, cin = 0, t, lofix, hifix;
    r = a; nf = f; w = (hl + pr) & 16'hFFFF;
    case (op)
      0, 1: begin
        if (op == 1) cin = cy;
        t = a + b + cin; r = t & 255;
        nf = pack(r, ((a & 15) + (b & 15) + cin) > 15, t > 255);
      end
      2, 3, 6: begin
        if (op == 3) cin = cy;
        t = a - b - cin;
        if (op != 6) r = t & 255;
        nf = pack(t & 255, ((a & 15) - (b & 15) - cin) < 0, t < 0);
      end
      4: begin r = (b + 1) & 255; nf = pack(r, (b & 15) == 15, cy); end
      5: begin r = (b - 1) & 255; nf = pack(r, (b & 15) == 0, cy); end
      7: begin r = a & b; nf = pack(r, 1, 0); end
      8: begin r = a | b; nf = pack(r, 0, 0); end
      9: begin r = a ^ b; nf = pack(r, 0, 0); end
      10: begin r = ((a << 1) | (a >> 7)) & 255; nf = (f & ~1) | (a >> 7); end
      11: begin r = (a >> 1) | ((a & 1) << 7); nf = (f & ~1) | (a & 1); end
      12: begin r = ((a << 1) | cy) & 255; nf = (f & ~1) | (a >> 7); end
      13: begin r = (a >> 1) | (cy << 7); nf = (f & ~1) | (a & 1); end
      14: r = (~a) & 255;
      15: nf = f | 1;
      16: nf = f ^ 1;
      17: begin
        lofix = ((a & 15) > 9) || ac;
        t = a + (lofix ? 6 : 0);
        hifix = (((t >> 4) & 15) > 9) || cy || (t > 255);
        r = (t + (hifix ? 96 : 0)) & 255;
        nf = pack(r, (a & 15) > 9, hifix);
      end
      18: nf = (f & ~1) | ((hl + pr) > 65535);
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input int op, input int a, input int b, input int hl, input int pr,
                      input bit v);
    int er, ew, ef;
    @(negedge clk);
    op_code = 5'(op); acc_in = 8'(a); opnd_in = 8'(b);
    hl_in = 16'(hl); pair_in = 16'(pr); op_valid = v;
    model(op, a, b, hl, pr, mflags, er, ew, ef);
    #1;
    check(tag_of(op), "result", int'(result), er);
    if (op == 18) check("R12", "hl_sum", int'(hl_sum), ew);
    @(posedge clk);
    if (v) mflags = ef;
    #1;
    check(v ? tag_of(op) : "R1", "flags", int'(flags), mflags);
  endtask

  task automatic preset(input int f);
    step(9, 0, 0, 0, 0, 1);
    if ((f & 1) != 0) step(15, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset flags", int'(flags), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(0, 8'h80, 8'h80, 0, 0, 1);
    step(0, 8'h0F, 8'h01, 0, 0, 1);
    step(1, 8'hFF, 8'h00, 0, 0, 1);
    step(0, 8'h12, 8'h34, 0, 0, 0);
    step(2, 8'h10, 8'h01, 0, 0, 1);
    step(3, 8'h00, 8'h00, 0, 0, 1);
    step(6, 8'h05, 8'h09, 0, 0, 1);
    step(6, 8'h42, 8'h42, 0, 0, 1);
    step(6, 8'h90, 8'h10, 0, 0, 1);
    step(15, 0, 0, 0, 0, 1);
    step(4, 0, 8'h0F, 0, 0, 1);
    step(5, 0, 8'h00, 0, 0, 1);
    step(4, 0, 8'hFF, 0, 0, 1);
    step(7, 8'hF0, 8'h0F, 0, 0, 1);
    step(8, 8'hF0, 8'h0F, 0, 0, 1);
    step(9, 8'hAA, 8'hAA, 0, 0, 1);
    step(7, 8'hFF, 8'hFF, 0, 0, 1);
    step(10, 8'h81, 0, 0, 0, 1);
    step(11, 8'h01, 0, 0, 0, 1);
    step(12, 8'h80, 0, 0, 0, 1);
    step(13, 8'h00, 0, 0, 0, 1);
    step(16, 0, 0, 0, 0, 1);
    step(14, 8'h5A, 0, 0, 0, 1);
    preset(0);
    step(17, 8'h9B, 0, 0, 0, 1);
    preset(0);
    step(0, 8'h09, 8'h09, 0, 0, 1);
    step(17, 8'h12, 0, 0, 0, 1);
    preset(0);
    step(17, 8'hFA, 0, 0, 0, 1);
    step(18, 0, 0, 16'hFFFF, 16'h0001, 1);
    step(18, 0, 0, 16'h1234, 16'h1111, 1);
    step(25, 8'h33, 8'h44, 0, 0, 1);
    for (int i = 0; i < 600; i++)
      step(int'($urandom_range(31)), int'($urandom_range(255)), int'($urandom_range(255)),
           int'($urandom_range(65535)), int'($urandom_range(65535)), ($urandom_range(7) != 0));
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule